// File: doc/BRIEF.md
# Linked-Descriptor Receive DMA Engine

This block takes received frames from a byte stream and stores each one in system memory. Software prepares a chain of receive descriptors. Each descriptor is four 32-bit words: a status word, a control word that holds the buffer size, a buffer address, and the address of the next descriptor. The engine works only on a descriptor whose ownership bit is set. It copies the frame bytes into that descriptor's buffer, writes a completion status back into the descriptor, and clears the ownership bit. It then moves to the descriptor named in the fourth word. It never moves to the next sequential address.

When the engine reaches a descriptor that it does not own, it raises an "unavailable" flag and stops accepting bytes. It stays stopped until software re-arms the descriptor and pulses the poll-demand input. Each completed frame sets a receive-interrupt flag, which drives the interrupt output. Both flags are cleared by a one-cycle clear pulse, which gives write-one-to-clear behaviour. The engine loads its list start address from the `listBase` input while it is stopped. It reaches memory through a simple port: read data arrives one cycle after the request, and writes carry byte enables.

Top module: `rxDescDma`

## Requirements
- R1: After reset the engine is stopped. `inReady`, `memRe`, `memWe`, `recvIntSt`, `unavailSt` and `irq` are all 0.
- R2: While `runEn` is 0, `inReady` stays 0, no memory read is issued, and the descriptor pointer follows `listBase`. When `runEn` goes to 1, the first descriptor fetched is the one at `listBase`.
- R3: The engine reads the status word at descriptor offset 0. If bit 31 (ownership) is 0, the engine sets `unavailSt`, holds `inReady` at 0, writes nothing, and suspends on that same descriptor.
- R4: A `pollDemand` pulse during suspension makes the engine fetch the same descriptor again. If ownership is now set, the engine receives into it.
- R5: Frame byte k is written to buffer address + k, little-endian within each 32-bit word (byte k goes to lane k mod 4). `memBe` enables only the lanes that hold frame bytes. Buffer addresses are word aligned.
- R6: The buffer size is control word bits 12:0. Bytes past the buffer size are never written to memory, and the frame is marked with an error.
- R7: The status write-back is a full-word write to descriptor offset 0, with these fields:
  - bit 31 = 0
  - bits 29:16 = total number of received bytes, including any dropped bytes
  - bit 15 = error summary, set when `inErr` accompanied any byte or when bytes were dropped
  - bit 9 = first-segment flag, always 1
  - bit 8 = last-segment flag, always 1
  - all other bits = 0
- R8: After write-back, the next descriptor used is the address taken from descriptor offset 12 (the fourth word).
- R9: A status write-back sets `recvIntSt`. `irq` equals `recvIntSt`. A `clrRecvInt` pulse clears `recvIntSt`.
- R10: A `clrUnavail` pulse clears `unavailSt`.
- R11: A memory read and a memory write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Engine run enable |
| listBase | input | ADDR_W | Start address of the descriptor chain, loaded while the engine is stopped |
| pollDemand | input | 1 | Pulse that resumes a suspended engine |
| inValid | input | 1 | Frame byte valid |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Marks the last byte of a frame |
| inErr | input | 1 | Receive error flag for this byte |
| inReady | output | 1 | Engine accepts a byte in this cycle |
| memRe | output | 1 | Memory read request; data returns on the next cycle |
| memWe | output | 1 | Memory write request |
| memAddr | output | ADDR_W | Memory byte address (word aligned) |
| memWdata | output | 32 | Memory write data |
| memBe | output | 4 | Write byte enables |
| memRdata | input | 32 | Memory read data |
| clrRecvInt | input | 1 | Write-one pulse that clears the receive-interrupt flag |
| clrUnavail | input | 1 | Write-one pulse that clears the unavailable flag |
| recvIntSt | output | 1 | Receive-interrupt status flag |
| unavailSt | output | 1 | Descriptor-unavailable status flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle, properties that hold whatever the stimulus:
- no read collides with a write;
- no buffer write lands at or beyond the buffer size;
- every rise of the receive-interrupt flag follows a full-word write that clears the ownership bit;
- the unavailable flag rises only after a descriptor status read.

Some behaviour needs a directed scenario instead. This covers following a non-sequential chain, truncating into a buffer whose size is not a multiple of four, resuming after a poll demand, and the exact length and flag fields of the status word. The bench shows these by comparing memory contents against a byte-level model.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;

  localparam int LEN_W  = 14;
  localparam int SIZE_W = 13;
  localparam int OWN_POS = 31;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_OWN,
    ST_CTRL,
    ST_BUF,
    ST_NEXT,
    ST_RECV,
    ST_FLUSH,
    ST_WBACK,
    ST_SUSP
  } rxState_e;

  typedef struct packed {
    logic       loadBase;
    logic       rdEn;
    logic [1:0] rdWord;
    logic       capCtrl;
    logic       capBuf;
    logic       capNext;
    logic       accept;
    logic       wrStat;
    logic       advance;
  } rxStrobe_t;

endpackage

// File: rtl/rxdmaCtrl.sv
module rxdmaCtrl
  import rxdma_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      runEn,
  input  logic      pollDemand,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      clrRecvInt,
  input  logic      clrUnavail,
  input  logic      ownBit,
  output rxStrobe_t str,
  output logic      inReady,
  output logic      recvIntSt,
  output logic      unavailSt
);

  rxState_e state, nextState;
  logic     setUnavail;

  always_comb begin
    str        = '0;
    nextState  = state;
    setUnavail = 1'b0;
    case (state)
      ST_IDLE: begin
        str.loadBase = 1'b1;
        if (runEn) nextState = ST_ISSUE;
      end
      ST_ISSUE: begin
        str.rdEn   = 1'b1;
        str.rdWord = 2'd0;
        nextState  = ST_OWN;
      end
      ST_OWN: begin
        if (ownBit) begin
          str.rdEn   = 1'b1;
          str.rdWord = 2'd1;
          nextState  = ST_CTRL;
        end else begin
          setUnavail = 1'b1;
          nextState  = ST_SUSP;
        end
      end
      ST_CTRL: begin
        str.capCtrl = 1'b1;
        str.rdEn    = 1'b1;
        str.rdWord  = 2'd2;
        nextState   = ST_BUF;
      end
      ST_BUF: begin
        str.capBuf = 1'b1;
        str.rdEn   = 1'b1;
        str.rdWord = 2'd3;
        nextState  = ST_NEXT;
      end
      ST_NEXT: begin
        str.capNext = 1'b1;
        nextState   = ST_RECV;
      end
      ST_RECV: begin
        if (inValid) begin
          str.accept = 1'b1;
          if (inLast) nextState = ST_FLUSH;
        end
      end
      ST_FLUSH: nextState = ST_WBACK;
      ST_WBACK: begin
        str.wrStat  = 1'b1;
        str.advance = 1'b1;
        nextState   = ST_ISSUE;
      end
      ST_SUSP: begin
        if (pollDemand)  nextState = ST_ISSUE;
        else if (!runEn) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      recvIntSt <= 1'b0;
      unavailSt <= 1'b0;
    end else begin
      state     <= nextState;
      recvIntSt <= (recvIntSt & ~clrRecvInt) | str.wrStat;
      unavailSt <= (unavailSt & ~clrUnavail) | setUnavail;
    end
  end

  assign inReady = (state == ST_RECV);

  // R3
  susp_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP) |-> (!str.accept && !str.rdEn && !str.wrStat));

  // R10
  unavail_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrUnavail && !setUnavail) |=> !unavailSt);

endmodule

// File: rtl/rxdmaPath.sv
module rxdmaPath
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         str,
  input  logic [ADDR_W-1:0] listBase,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic              inErr,
  input  logic [31:0]       memRdata,
  output logic              ownBit,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe
);

  logic [ADDR_W-1:0] curDesc, nextDesc, bufAddr, wrAddr;
  logic [SIZE_W-1:0] bufSize;
  logic [LEN_W-1:0]  byteCnt;
  logic              errAcc;
  logic [31:0]       packWord, wrData, mergedWord, statWord;
  logic [3:0]        packBe, wrBe, mergedBe;
  logic              wrPend;
  logic [1:0]        lane;
  logic              stored, lastStored;

  assign ownBit     = memRdata[OWN_POS];
  assign lane       = byteCnt[1:0];
  assign stored     = byteCnt < LEN_W'(bufSize);
  assign lastStored = (byteCnt + LEN_W'(1)) == LEN_W'(bufSize);

  always_comb begin
    mergedWord = (lane == 2'd0) ? 32'd0 : packWord;
    mergedBe   = (lane == 2'd0) ? 4'd0  : packBe;
    mergedWord[8*lane +: 8] = inData;
    mergedBe[lane]          = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc  <= '0;
      nextDesc <= '0;
      bufAddr  <= '0;
      bufSize  <= '0;
      byteCnt  <= '0;
      errAcc   <= 1'b0;
      packWord <= '0;
      packBe   <= '0;
      wrData   <= '0;
      wrBe     <= '0;
      wrAddr   <= '0;
      wrPend   <= 1'b0;
    end else begin
      wrPend <= 1'b0;
      if (str.loadBase) curDesc <= listBase;
      if (str.advance)  curDesc <= nextDesc;
      if (str.capCtrl)  bufSize <= memRdata[SIZE_W-1:0];
      if (str.capBuf)   bufAddr <= ADDR_W'(memRdata);
      if (str.capNext) begin
        nextDesc <= ADDR_W'(memRdata);
        byteCnt  <= '0;
        errAcc   <= 1'b0;
        packBe   <= '0;
      end
      if (str.accept) begin
        errAcc <= errAcc | inErr | !stored;
        if (byteCnt != '1) byteCnt <= byteCnt + LEN_W'(1);
        if (stored) begin
          packWord <= mergedWord;
          packBe   <= mergedBe;
          if (lane == 2'd3 || inLast || lastStored) begin
            wrPend <= 1'b1;
            wrData <= mergedWord;
            wrBe   <= mergedBe;
            wrAddr <= bufAddr + ADDR_W'({byteCnt[LEN_W-1:2], 2'b00});
          end
        end
      end
    end
  end

  assign statWord = {2'b00, byteCnt, errAcc, 5'b00000, 1'b1, 1'b1, 8'h00};

  assign memRe    = str.rdEn;
  assign memWe    = str.wrStat | wrPend;
  assign memAddr  = str.rdEn   ? (curDesc + ADDR_W'({str.rdWord, 2'b00})) :
                    str.wrStat ? curDesc : wrAddr;
  assign memWdata = str.wrStat ? statWord : wrData;
  assign memBe    = str.wrStat ? 4'hF : wrBe;

  // R11
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(str.rdEn && (str.wrStat || wrPend)));

  // R6
  buf_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPend && !str.wrStat) |-> ((memAddr - bufAddr) < ADDR_W'(bufSize)));

  // R5
  be_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memBe != 4'h0));

endmodule

// File: rtl/rxDescDma.sv
module rxDescDma
  import rxdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [ADDR_W-1:0] listBase,
  input  logic              pollDemand,
  input  logic              inValid,
  input  logic [7:0]        inData,
  input  logic              inLast,
  input  logic              inErr,
  output logic              inReady,
  output logic              memRe,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWdata,
  output logic [3:0]        memBe,
  input  logic [31:0]       memRdata,
  input  logic              clrRecvInt,
  input  logic              clrUnavail,
  output logic              recvIntSt,
  output logic              unavailSt,
  output logic              irq
);

  rxStrobe_t str;
  logic      ownBit;

  rxdmaCtrl ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .pollDemand(pollDemand),
    .inValid(inValid), .inLast(inLast), .clrRecvInt(clrRecvInt),
    .clrUnavail(clrUnavail), .ownBit(ownBit), .str(str),
    .inReady(inReady), .recvIntSt(recvIntSt), .unavailSt(unavailSt)
  );

  rxdmaPath #(.ADDR_W(ADDR_W)) path (
    .clk(clk), .rstN(rstN), .str(str), .listBase(listBase),
    .inData(inData), .inLast(inLast), .inErr(inErr), .memRdata(memRdata),
    .ownBit(ownBit), .memRe(memRe), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memBe(memBe)
  );

  assign irq = recvIntSt;

  // R9
  int_after_wb_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recvIntSt) |-> ($past(memWe) && $past(memBe) == 4'hF && !$past(memWdata[OWN_POS])));

  // R3
  unavail_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unavailSt) |-> $past(memRe, 2));

  // R2
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !inReady && !unavailSt && !$past(runEn)) |-> !memWe);

endmodule

// File: tb/rxDescDma_test.sv
`timescale 1ns/1ps
module rxDescDma_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [31:0] listBase = 32'h100;
  logic        pollDemand = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  inData = 8'h00;
  logic        inLast = 1'b0;
  logic        inErr = 1'b0;
  logic        inReady, memRe, memWe, recvIntSt, unavailSt, irq;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  memBe;
  logic        clrRecvInt = 1'b0;
  logic        clrUnavail = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] mem [0:4095];
  int expDesc = 0;
  int expBuf  = 0;
  int expSize = 0;
  int readsWhileStopped = 0;

  always #2 clk = ~clk;

  rxDescDma uut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .listBase(listBase),
    .pollDemand(pollDemand), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inErr(inErr), .inReady(inReady), .memRe(memRe),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata), .memBe(memBe),
    .memRdata(memRdata), .clrRecvInt(clrRecvInt), .clrUnavail(clrUnavail),
    .recvIntSt(recvIntSt), .unavailSt(unavailSt), .irq(irq)
  );

  always @(posedge clk) begin
    if (memRe)
      memRdata <= {mem[memAddr[11:0]+3], mem[memAddr[11:0]+2],
                   mem[memAddr[11:0]+1], mem[memAddr[11:0]]};
    if (memWe)
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[11:0]+b] = memWdata[8*b +: 8];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference checks made on every clock: write window (R5, R6) and irq (R9).
  always @(negedge clk) begin
    if (rstN) begin
      if (!runEn && memRe) readsWhileStopped++;
      if (irq !== recvIntSt) check(0, "R9 irq", irq, recvIntSt);
      if (memWe) begin
        if (memAddr == expDesc)
          check(memBe == 4'hF, "R7 status write full word", memBe, 4'hF);
        else
          check(memAddr >= expBuf && memAddr < expBuf + expSize,
                "R6 write inside buffer", memAddr, expBuf);
      end
    end
  end

  task automatic putWord(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[a+b] = v[8*b +: 8];
  endtask

  function automatic logic [31:0] getWord(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  task automatic setupDesc(input int d, input bit own, input int size, input int bufA, input int nxt);
    putWord(d,    {own, 31'd0});
    putWord(d+4,  32'h4000 | size);
    putWord(d+8,  bufA);
    putWord(d+12, nxt);
    for (int i = 0; i < 128; i++) mem[bufA+i] = 8'hEE;
  endtask

  task automatic sendFrame(input int len, input int seed, input bit err);
    for (int i = 0; i < len; i++) begin
      inValid = 1'b1;
      inData  = 8'(seed + i);
      inLast  = (i == len - 1);
      inErr   = err && (i == len - 1);
      forever begin
        #1;
        if (inReady) begin @(negedge clk); break; end
        @(negedge clk);
      end
    end
    inValid = 1'b0; inLast = 1'b0; inErr = 1'b0;
  endtask

  task automatic waitRecvInt();
    for (int i = 0; i < 400 && !recvIntSt; i++) @(negedge clk);
  endtask

  task automatic clearInt();
    clrRecvInt = 1'b1; @(negedge clk); clrRecvInt = 1'b0;
  endtask

  task automatic checkFrame(input int d, input int bufA, input int size, input int len,
                            input int seed, input bit err, input string req);
    int stor;
    logic [31:0] expStat;
    bit bytesOk;
    stor = (len < size) ? len : size;
    expStat = (32'(len) << 16) | ((err || len > size) ? 32'h8000 : 32'h0) | 32'h300;
    check(getWord(d) == expStat, {req, " R7 status word"}, getWord(d), expStat);
    bytesOk = 1;
    for (int i = 0; i < stor; i++) if (mem[bufA+i] != 8'(seed + i)) bytesOk = 0;
    check(bytesOk, {req, " R5 stored bytes"}, bytesOk, 1);
    bytesOk = 1;
    for (int i = stor; i < stor + 8; i++) if (mem[bufA+i] != 8'hEE) bytesOk = 0;
    check(bytesOk, {req, " R6 no write past data/buffer"}, bytesOk, 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    setupDesc(32'h100, 1, 64, 32'h800, 32'h300);
    setupDesc(32'h300, 1, 64, 32'hA00, 32'h200);
    setupDesc(32'h200, 1, 64, 32'h900, 32'h100);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!inReady && !memRe && !memWe, "R1 idle port", {inReady, memRe, memWe}, 0);
    check(!recvIntSt && !unavailSt && !irq, "R1 flags", {recvIntSt, unavailSt, irq}, 0);
    repeat (10) @(negedge clk);
    // R2 stopped engine issues nothing
    check(readsWhileStopped == 0 && !inReady, "R2 stopped", readsWhileStopped, 0);

    // R2 R8 first descriptor at listBase, frame 1
    expDesc = 32'h100; expBuf = 32'h800; expSize = 64;
    runEn = 1'b1;
    sendFrame(10, 8'h10, 0);
    waitRecvInt();
    check(recvIntSt && irq, "R9 flag set", recvIntSt, 1);
    checkFrame(32'h100, 32'h800, 64, 10, 8'h10, 0, "f1");
    clearInt();
    check(!recvIntSt && !irq, "R9 flag cleared", recvIntSt, 0);

    // R8 next pointer 0x300 (not sequential), error frame
    expDesc = 32'h300; expBuf = 32'hA00; expSize = 64;
    sendFrame(8, 8'h40, 1);
    waitRecvInt();
    checkFrame(32'h300, 32'hA00, 64, 8, 8'h40, 1, "f2 R8");
    clearInt();

    // R6 truncation 70 bytes into 64
    expDesc = 32'h200; expBuf = 32'h900; expSize = 64;
    sendFrame(70, 8'h80, 0);
    waitRecvInt();
    checkFrame(32'h200, 32'h900, 64, 70, 8'h80, 0, "f3 R6");
    clearInt();

    // R3 chain returns to 0x100, now owned by software
    expDesc = 32'h100; expBuf = 32'h800; expSize = 0;
    repeat (12) @(negedge clk);
    check(unavailSt, "R3 unavailable set", unavailSt, 1);
    check(!inReady, "R3 no accept when suspended", inReady, 0);
    check(getWord(32'h100) == 32'h000A0300, "R3 descriptor untouched", getWord(32'h100), 32'h000A0300);
    clrUnavail = 1'b1; @(negedge clk); clrUnavail = 1'b0;
    check(!unavailSt, "R10 unavailable cleared", unavailSt, 1'b0);

    // R4 re-arm with odd size 6, poll demand
    setupDesc(32'h100, 1, 6, 32'h800, 32'h300);
    expSize = 6;
    repeat (3) @(negedge clk);
    check(!inReady, "R4 waits for poll", inReady, 0);
    pollDemand = 1'b1; @(negedge clk); pollDemand = 1'b0;
    sendFrame(9, 8'hC0, 0);
    waitRecvInt();
    checkFrame(32'h100, 32'h800, 6, 9, 8'hC0, 0, "f4 R4 R6");
    clearInt();
    repeat (12) @(negedge clk);
    check(unavailSt, "R3 suspended at 0x300", unavailSt, 1);
    finishRun();
  end

endmodule